// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block maps addresses leaving the CPU side of a host bridge onto addresses for the external bus. It holds a small, parameterised set of outbound translation windows. Each window has a base, an inclusive upper bound, a target and a transaction kind, which is one of memory, I/O, configuration type 0 or configuration type 1. For a configuration window the target word carries the bus, device and function identifier of the device being reached. Each lookup of a 64-bit address returns the translated address and the kind of the window it fell into. When no enabled window covers the address, the block raises a miss flag and returns the address unchanged.

Software never addresses a window directly. It first writes a selector register that names a direction and a window number. All later field accesses go to the window that the selector names. The register window sits at a parameterised base offset, 0x900 by default. The selector is at offset +0x00 and the window fields follow at fixed offsets. Register reads are combinational from the configuration address. The lookup path is one register stage deep.

Top module: `ob_xlat`

## Requirements
- R1: After reset every window is disabled and has all fields zero, the selector reads 0, `rsp_valid` is 0, and any lookup misses.
- R2: A write to offset +0x00 stores bit 31 (1 selects inbound, 0 selects outbound) and bits 7:0 (the window number). A read of +0x00 returns those two fields, with all other bits zero.
- R3: While the selector names outbound window n, with n below the window count, writes to the field offsets update window n and reads of those offsets return window n's fields. The fields are: kind in bits 2:0 at +0x04; enable in bit 31 and a bar-mode flag in bit 30 at +0x08; base low at +0x0C; base high at +0x10; bound low at +0x14; target low at +0x18; target high at +0x1C.
- R4: While the selector names the inbound direction or a window number at or above the window count, writes to the field offsets change no window, and reads of the field offsets return 0.
- R5: A window covers an address only when it is enabled and the address lies between its base and {base[63:32], bound} inclusive. The base and the upper bound both hit, and one address past either edge does not hit.
- R6: On a hit the response address is target + (address − base), modulo 2^64, and `rsp_kind` is the window's kind code (0 memory, 2 I/O, 4 config type 0, 5 config type 1).
- R7: When several enabled windows cover an address, the lowest-numbered window supplies the response.
- R8: When no window covers the address, `rsp_miss` is 1, `rsp_addr` equals the request address and `rsp_kind` is 0.
- R9: `rsp_valid` in a cycle equals `req_valid` one cycle earlier. Each response belongs to the request of the previous cycle, including during back-to-back requests.
- R10: The bar-mode flag is stored and reads back, but it has no effect on matching or translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 64 | CPU-side address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_miss | output | 1 | No enabled window covered the address |
| rsp_addr | output | 64 | Translated address, or the request address on a miss |
| rsp_kind | output | 3 | Transaction kind of the window that hit |

## Verification
Lookups are placed exactly on the base, exactly on the upper bound, and one address outside each edge. These separate an inclusive compare from an exclusive one and also catch a bound that is extended with the wrong upper half. A second window overlaps the first, which shows whether the lower-numbered window takes priority. Disabling the first window then exposes the second, whose configuration target identifier and kind must come through unchanged. Field writes are issued under an inbound selector and under an out-of-range selector to show that neither one leaks into a window. Requests are also sent back to back and separated by idle cycles, to expose a response stage that drops or repeats a result.

// File: rtl/ob_xlat_pkg.sv
package ob_xlat_pkg;
  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;
  localparam int KIND_W = 3;

  // field offsets inside the register window (decoded, so fixed)
  localparam logic [4:0] OFS_VIEW = 5'h00;
  localparam logic [4:0] OFS_KIND = 5'h04;
  localparam logic [4:0] OFS_CTL  = 5'h08;
  localparam logic [4:0] OFS_BLO  = 5'h0C;
  localparam logic [4:0] OFS_BHI  = 5'h10;
  localparam logic [4:0] OFS_LIM  = 5'h14;
  localparam logic [4:0] OFS_TLO  = 5'h18;
  localparam logic [4:0] OFS_THI  = 5'h1C;

  typedef struct packed {
    logic              en;
    logic              bar;
    logic [KIND_W-1:0] kind;
    logic [ADDR_W-1:0] base;
    logic [WORD_W-1:0] lim;
    logic [ADDR_W-1:0] tgt;
  } window_t;
endpackage

// File: rtl/ob_xlat_regs.sv
module ob_xlat_regs
  import ob_xlat_pkg::*;
#(
  parameter int          NUM_WIN  = 2,
  parameter int          VP_IDX_W = 8,
  parameter logic [11:0] WIN_BASE = 12'h900
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_wr_i,
  input  logic [11:0]                     cfg_addr_i,
  input  logic [WORD_W-1:0]               cfg_wdata_i,
  output logic [WORD_W-1:0]               cfg_rdata_o,
  output logic [NUM_WIN-1:0]              en_o,
  output logic [NUM_WIN-1:0][KIND_W-1:0]  kind_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  base_o,
  output logic [NUM_WIN-1:0][WORD_W-1:0]  lim_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  tgt_o
);
  localparam int PAD_W = WORD_W - 1 - VP_IDX_W;

  window_t [NUM_WIN-1:0] win_q, win_d;
  logic                  vp_dir_q, vp_dir_d;
  logic [VP_IDX_W-1:0]   vp_idx_q, vp_idx_d;

  logic       in_win;
  logic [4:0] fld;
  logic       sel_ok;
  window_t    cur;

  assign in_win = (cfg_addr_i[11:5] == WIN_BASE[11:5]) && (cfg_addr_i[1:0] == 2'b00);
  assign fld    = cfg_addr_i[4:0];
  assign sel_ok = !vp_dir_q && (32'(vp_idx_q) < NUM_WIN);

  // next state
  always_comb begin
    win_d    = win_q;
    vp_dir_d = vp_dir_q;
    vp_idx_d = vp_idx_q;
    if (cfg_wr_i && in_win) begin
      if (fld == OFS_VIEW) begin
        vp_dir_d = cfg_wdata_i[WORD_W-1];
        vp_idx_d = cfg_wdata_i[VP_IDX_W-1:0];
      end else if (sel_ok) begin
        for (int i = 0; i < NUM_WIN; i++) begin
          if (vp_idx_q == VP_IDX_W'(i)) begin
            case (fld)
              OFS_KIND: win_d[i].kind = cfg_wdata_i[KIND_W-1:0];
              OFS_CTL: begin
                win_d[i].en  = cfg_wdata_i[31];
                win_d[i].bar = cfg_wdata_i[30];
              end
              OFS_BLO: win_d[i].base[31:0]  = cfg_wdata_i;
              OFS_BHI: win_d[i].base[63:32] = cfg_wdata_i;
              OFS_LIM: win_d[i].lim         = cfg_wdata_i;
              OFS_TLO: win_d[i].tgt[31:0]   = cfg_wdata_i;
              OFS_THI: win_d[i].tgt[63:32]  = cfg_wdata_i;
              default: ;
            endcase
          end
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= '0;
      vp_dir_q <= 1'b0;
      vp_idx_q <= '0;
    end else begin
      win_q    <= win_d;
      vp_dir_q <= vp_dir_d;
      vp_idx_q <= vp_idx_d;
    end
  end

  // read path
  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (vp_idx_q == VP_IDX_W'(i)) cur = win_q[i];
    cfg_rdata_o = '0;
    if (in_win) begin
      if (fld == OFS_VIEW) begin
        cfg_rdata_o = {vp_dir_q, {PAD_W{1'b0}}, vp_idx_q};
      end else if (sel_ok) begin
        case (fld)
          OFS_KIND: cfg_rdata_o = {{(WORD_W-KIND_W){1'b0}}, cur.kind};
          OFS_CTL:  cfg_rdata_o = {cur.en, cur.bar, 30'b0};
          OFS_BLO:  cfg_rdata_o = cur.base[31:0];
          OFS_BHI:  cfg_rdata_o = cur.base[63:32];
          OFS_LIM:  cfg_rdata_o = cur.lim;
          OFS_TLO:  cfg_rdata_o = cur.tgt[31:0];
          OFS_THI:  cfg_rdata_o = cur.tgt[63:32];
          default:  cfg_rdata_o = '0;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_out
    assign en_o[g]   = win_q[g].en;
    assign kind_o[g] = win_q[g].kind;
    assign base_o[g] = win_q[g].base;
    assign lim_o[g]  = win_q[g].lim;
    assign tgt_o[g]  = win_q[g].tgt;
  end

  // R4
  bad_sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && in_win && (fld != OFS_VIEW) && !sel_ok) |=> $stable(win_q));
endmodule

// File: rtl/ob_xlat_match.sv
module ob_xlat_match
  import ob_xlat_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [NUM_WIN-1:0]             en_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] base_i,
  input  logic [NUM_WIN-1:0][WORD_W-1:0] lim_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] tgt_i,
  output logic [NUM_WIN-1:0]             hit_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] xlat_o
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [ADDR_W-1:0] top_addr;
    assign top_addr  = {base_i[g][ADDR_W-1:WORD_W], lim_i[g]};
    assign hit_o[g]  = en_i[g] && (addr_i >= base_i[g]) && (addr_i <= top_addr);
    assign xlat_o[g] = tgt_i[g] + (addr_i - base_i[g]);
  end
endmodule

// File: rtl/ob_xlat_pick.sv
module ob_xlat_pick
  import ob_xlat_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid_i,
  input  logic [ADDR_W-1:0]               req_addr_i,
  input  logic [NUM_WIN-1:0]              hit_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xlat_i,
  input  logic [NUM_WIN-1:0][KIND_W-1:0]  kind_i,
  output logic                            rsp_valid_o,
  output logic                            rsp_miss_o,
  output logic [ADDR_W-1:0]               rsp_addr_o,
  output logic [KIND_W-1:0]               rsp_kind_o
);
  logic              any_hit;
  logic [ADDR_W-1:0] sel_addr;
  logic [KIND_W-1:0] sel_kind;
  logic              miss_d;
  logic [ADDR_W-1:0] addr_d;
  logic [KIND_W-1:0] kind_d;
  logic              valid_q, miss_q;
  logic [ADDR_W-1:0] addr_q;
  logic [KIND_W-1:0] kind_q;

  // lowest index wins
  always_comb begin
    any_hit  = 1'b0;
    sel_addr = '0;
    sel_kind = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_i[i] && !any_hit) begin
        any_hit  = 1'b1;
        sel_addr = xlat_i[i];
        sel_kind = kind_i[i];
      end
    end
    miss_d = !any_hit;
    addr_d = any_hit ? sel_addr : req_addr_i;
    kind_d = any_hit ? sel_kind : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      miss_q  <= 1'b0;
      addr_q  <= '0;
      kind_q  <= '0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) begin
        miss_q <= miss_d;
        addr_q <= addr_d;
        kind_q <= kind_d;
      end
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_miss_o  = miss_q;
  assign rsp_addr_o  = addr_q;
  assign rsp_kind_o  = kind_q;

  // R9
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (valid_q == $past(req_valid_i)));

  // R8
  miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && valid_q && miss_q) |-> (addr_q == $past(req_addr_i)));

  // R5
  no_hit_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && valid_q && $past(hit_i == '0)) |-> miss_q);

  // R7
  low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && valid_q && $past(hit_i[0])) |-> (addr_q == $past(xlat_i[0])));
endmodule

// File: rtl/ob_xlat.sv
module ob_xlat
  import ob_xlat_pkg::*;
#(
  parameter int          NUM_WIN  = 2,
  parameter int          VP_IDX_W = 8,
  parameter logic [11:0] WIN_BASE = 12'h900
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic [63:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_miss,
  output logic [63:0] rsp_addr,
  output logic [2:0]  rsp_kind
);
  logic [NUM_WIN-1:0]             en;
  logic [NUM_WIN-1:0][KIND_W-1:0] kind;
  logic [NUM_WIN-1:0][ADDR_W-1:0] base;
  logic [NUM_WIN-1:0][WORD_W-1:0] lim;
  logic [NUM_WIN-1:0][ADDR_W-1:0] tgt;
  logic [NUM_WIN-1:0]             hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0] xlat;

  ob_xlat_regs #(.NUM_WIN(NUM_WIN), .VP_IDX_W(VP_IDX_W), .WIN_BASE(WIN_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .en_o(en), .kind_o(kind), .base_o(base), .lim_o(lim), .tgt_o(tgt)
  );

  ob_xlat_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr_i(req_addr), .en_i(en), .base_i(base), .lim_i(lim), .tgt_i(tgt),
    .hit_o(hit), .xlat_o(xlat)
  );

  ob_xlat_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .hit_i(hit), .xlat_i(xlat), .kind_i(kind),
    .rsp_valid_o(rsp_valid), .rsp_miss_o(rsp_miss),
    .rsp_addr_o(rsp_addr), .rsp_kind_o(rsp_kind)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !rsp_valid);
endmodule

// File: tb/sim_ob_xlat.sv
`timescale 1ns/100ps
module sim_ob_xlat;
  localparam logic [11:0] WB = 12'h900;
  localparam int NW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = 12'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = 64'h0;
  logic        rsp_valid, rsp_miss;
  logic [63:0] rsp_addr;
  logic [2:0]  rsp_kind;

  int n_run = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  // behavioural model state
  bit          m_dir;
  logic [7:0]  m_idx;
  bit          m_en  [NW];
  bit          m_bar [NW];
  logic [2:0]  m_kind[NW];
  logic [63:0] m_base[NW];
  logic [31:0] m_lim [NW];
  logic [63:0] m_tgt [NW];

  bit          q_v[$];
  bit          q_m[$];
  logic [63:0] q_a[$];
  logic [2:0]  q_k[$];
  string       q_t[$];

  ob_xlat u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
    .rsp_addr(rsp_addr), .rsp_kind(rsp_kind)
  );

  always #2.5 clk = ~clk;

  function automatic bit sel_ok();
    return !m_dir && (m_idx < 8'(NW));
  endfunction

  function automatic logic [31:0] mread(input logic [4:0] ofs);
    int s;
    s = int'(m_idx);
    if (ofs == 5'h00) return {m_dir, 23'b0, m_idx};
    if (!sel_ok()) return 32'h0;
    case (ofs)
      5'h04: return {29'b0, m_kind[s]};
      5'h08: return {m_en[s], m_bar[s], 30'b0};
      5'h0C: return m_base[s][31:0];
      5'h10: return m_base[s][63:32];
      5'h14: return m_lim[s];
      5'h18: return m_tgt[s][31:0];
      5'h1C: return m_tgt[s][63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_lookup(input logic [63:0] a, output bit miss,
                              output logic [63:0] o, output logic [2:0] k);
    miss = 1'b1; o = a; k = 3'd0;
    for (int i = 0; i < NW; i++) begin
      if (miss && m_en[i] && a >= m_base[i] && a <= {m_base[i][63:32], m_lim[i]}) begin
        miss = 1'b0;
        o = m_tgt[i] + (a - m_base[i]);
        k = m_kind[i];
      end
    end
  endtask

  // reference: expectation built at each edge from the sampled request
  always @(posedge clk) begin
    bit mi; logic [63:0] o; logic [2:0] k;
    if (rst_n) begin
      model_lookup(req_addr, mi, o, k);
      q_v.push_back(req_valid);
      q_m.push_back(mi);
      q_a.push_back(o);
      q_k.push_back(k);
      q_t.push_back(cur_tag);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (q_v.size() > 0) begin
      bit v, mi; logic [63:0] a; logic [2:0] k; string t;
      v = q_v.pop_front(); mi = q_m.pop_front(); a = q_a.pop_front();
      k = q_k.pop_front(); t = q_t.pop_front();
      n_run++;
      if (rsp_valid !== v) begin
        n_fail++;
        $display("FAIL R9 rsp_valid act=%0b exp=%0b", rsp_valid, v);
      end
      if (v) begin
        n_run++;
        if (rsp_miss !== mi || rsp_addr !== a || rsp_kind !== k) begin
          n_fail++;
          $display("FAIL %s/%s miss/addr/kind act=%0b/%h/%0d exp=%0b/%h/%0d",
                   t, mi ? "R8" : "R6", rsp_miss, rsp_addr, rsp_kind, mi, a, k);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] ofs, input logic [31:0] d);
    int s;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = WB + 12'(ofs); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    s = int'(m_idx);
    if (ofs == 5'h00) begin
      m_dir = d[31]; m_idx = d[7:0];
    end else if (sel_ok()) begin
      case (ofs)
        5'h04: m_kind[s] = d[2:0];
        5'h08: begin m_en[s] = d[31]; m_bar[s] = d[30]; end
        5'h0C: m_base[s][31:0]  = d;
        5'h10: m_base[s][63:32] = d;
        5'h14: m_lim[s] = d;
        5'h18: m_tgt[s][31:0]  = d;
        5'h1C: m_tgt[s][63:32] = d;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [4:0] ofs, input string tag);
    logic [31:0] e;
    @(negedge clk);
    cfg_addr = WB + 12'(ofs);
    #1;
    e = mread(ofs);
    n_run++;
    if (cfg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read +%h act=%h exp=%h", tag, ofs, cfg_rdata, e);
    end
  endtask

  task automatic look(input logic [63:0] a, input string tag);
    @(negedge clk);
    cur_tag = tag; req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic prog(input logic [7:0] idx, input logic [2:0] k, input logic [63:0] b,
                      input logic [31:0] l, input logic [63:0] t, input logic [31:0] ctl);
    wr(5'h00, {24'h0, idx});
    wr(5'h04, {29'h0, k});
    wr(5'h0C, b[31:0]);
    wr(5'h10, b[63:32]);
    wr(5'h14, l);
    wr(5'h18, t[31:0]);
    wr(5'h1C, t[63:32]);
    wr(5'h08, ctl);
  endtask

  initial begin
    m_dir = 0; m_idx = 0;
    for (int i = 0; i < NW; i++) begin
      m_en[i] = 0; m_bar[i] = 0; m_kind[i] = 0;
      m_base[i] = 0; m_lim[i] = 0; m_tgt[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    n_run++;
    if (rsp_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1 rsp_valid act=%0b exp=0", rsp_valid);
    end
    rd(5'h00, "R1");
    rd(5'h08, "R1");
    rd(5'h14, "R1");
    look(64'h0, "R1");
    look(64'h1_4000_0000, "R1");

    // R3 program window 0: memory kind
    prog(8'd0, 3'd0, 64'h1_4000_0000, 32'h4000_FFFF, 64'h8000_0000, 32'h8000_0000);
    rd(5'h00, "R2");
    for (int o = 4; o <= 28; o += 4) rd(5'(o), "R3");

    // R5 edges, R6 translation
    look(64'h1_4000_0000, "R5");
    look(64'h1_4000_FFFF, "R5");
    look(64'h1_4001_0000, "R5");
    look(64'h1_3FFF_FFFF, "R5");
    look(64'h1_4000_1234, "R6");

    // window 1: config type 0 with bus 3 dev 2 fn 1, bar flag set, overlaps window 0
    prog(8'd1, 3'd4, 64'h1_4000_8000, 32'h4000_8FFF, 64'h0311_0000, 32'hC000_0000);
    rd(5'h08, "R10");
    rd(5'h18, "R3");
    look(64'h1_4000_8010, "R7");
    // disable window 0 -> window 1 serves
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h0);
    look(64'h1_4000_8010, "R6");
    look(64'h1_4000_8FFF, "R10");
    look(64'h1_4000_9000, "R5");

    // R4 inbound selection
    wr(5'h00, 32'h8000_0001);
    rd(5'h00, "R2");
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h08, 32'h0);
    rd(5'h14, "R4");
    rd(5'h08, "R4");
    // out-of-range window number
    wr(5'h00, 32'h0000_0005);
    rd(5'h00, "R2");
    wr(5'h0C, 32'h0);
    wr(5'h08, 32'h0);
    rd(5'h0C, "R4");
    wr(5'h00, 32'h0000_0001);
    rd(5'h14, "R4");
    rd(5'h0C, "R4");
    rd(5'h08, "R4");
    look(64'h1_4000_8020, "R4");

    // R9 back-to-back requests
    @(negedge clk);
    cur_tag = "R9"; req_valid = 1'b1; req_addr = 64'h1_4000_8001;
    @(negedge clk); req_addr = 64'h1_4000_0001;
    @(negedge clk); req_addr = 64'h1_4000_8FFF;
    @(negedge clk); req_valid = 1'b0; req_addr = 64'h1_4000_8004;
    @(negedge clk); req_valid = 1'b1; req_addr = 64'h0;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule